// File: doc/BRIEF.md
# Chained Frame Descriptor Fetcher

This block walks a set of display DMA channels once per frame and refreshes each enabled channel's working registers from a four-word descriptor held in memory. On a frame-start pulse it first zeroes the source register of every channel. It then visits the channels one at a time in ascending index order. For each enabled channel it chooses where the next descriptor lives and checks that the whole descriptor fits inside one of two memory windows. If it fits, the block reads the four words and loads them into the channel. It then checks the loaded frame source address.

Each channel has a linked-list pointer register that software can write. It also has a one-shot branch register that redirects the chain for a single frame and can raise a branch-status event. Bus-error events carry the number of the offending channel. Software reaches all of this through a small register interface with a combinational read path.

The memory read port is a valid/ready stream with one word per handshake:

- A request keeps `mem_req_valid` high and holds `mem_req_addr` unchanged until `mem_req_ready` is sampled high.
- After an accepted request, the block raises `mem_rsp_ready` and waits for exactly one `mem_rsp_valid` beat. It issues no new request until that beat arrives.
- At most one word is ever outstanding.
- The four words of a descriptor are requested at ascending byte addresses. Each address is 4 greater than the previous one, so the words arrive in little-endian word order.

Top module: `frame_desc_fetcher`

## Requirements
- R1: After reset, every readable register returns zero, `busy` is low, no event is raised and no memory request is made.
- R2: Register map. Channel k has a block at byte address 0x200 + 16·k, with these words:
  - +0x0: next-descriptor pointer, read/write. A write stores the data ANDed with 0xFFFFFFF0.
  - +0x4: frame source, read-only.
  - +0x8: frame ID, read-only.
  - +0xC: command, read-only.
  Writes to the read-only words change nothing.
- R3: Branch register. Channel k's branch register is at byte address 0x100 + 4·k. A write stores the data ANDed with 0xFFFFFFF3. Its fields are:
  - bit 0: redirect request.
  - bit 1: raise an event on redirect.
  - bits 31:4: redirect descriptor address, in 16-byte units.
- R4: A frame start accepted while idle clears the source register of every channel in the next cycle. A disabled channel makes no memory request and keeps its pointer, ID and command.
- R5: An enabled channel reads four words at P, P+4, P+8 and P+12, where P is the chosen pointer. Those words load, in order, the pointer, source, ID and command registers.
- R6: When bit 0 of the branch register is set, P comes from the branch address instead of the pointer register. Bit 0 then clears and the other bits stay. `bs_event[k]` pulses for one cycle only if bit 1 is also set. This means the next frame follows the loaded linked-list pointer again.
- R7: If P..P+15 does not lie wholly inside one of the two windows, the channel reads nothing and its source stays zero. A descriptor ending exactly at a window's end is fetched.
- R8: After each enabled channel is handled, `ber_event` pulses for one cycle with `ber_chan` set to the channel index, in two cases:
  - its source is zero;
  - its source lies outside both windows.
  For this check, a source equal to a window's end address counts as inside.
- R9: Channels are handled in ascending index order. `busy` rises the cycle after an accepted frame start and stays high until the last channel is done. A frame start while busy is ignored.
- R10: Memory requests follow the valid/ready rules above. The address is held stable while it is stalled, and only one word is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that starts a pass over the channels |
| chan_en | input | NCH | Per-channel enable |
| reg_addr | input | REG_AW | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr`; zero when unmapped |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Response word valid |
| mem_rsp_ready | output | 1 | Block waits for a response |
| mem_rsp_data | input | 32 | Response word |
| busy | output | 1 | A pass over the channels is in progress |
| bs_event | output | NCH | One-cycle branch-status event per channel |
| ber_event | output | 1 | One-cycle bus-error event |
| ber_chan | output | CW | Channel index for `ber_event` |

## Verification
The assertions rely on the following from the environment:

- Memory answers each accepted request with exactly one response beat, and never sends a response without a request.
- `frame_start` is a single-cycle pulse.
- The two windows neither wrap the 32-bit address space nor leave the request address unaligned.

The behavioural memory in the bench respects all of these. It registers one pending word per accepted request, and it delays both acceptance and response in a stall mode. The bench reaches every descriptor and source boundary through the normal register and memory interfaces.

// File: rtl/fdf_pkg.sv
package fdf_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PICK,
    S_REQ,
    S_RSP,
    S_CHECK,
    S_NEXT
  } seq_state_t;

  localparam logic [31:0] PTR_MASK    = 32'hFFFF_FFF0;
  localparam logic [31:0] BRANCH_MASK = 32'hFFFF_FFF3;
  localparam logic [31:0] DESC_BYTES  = 32'd16;

  // whole span [a, a+len) inside [base, base+size)
  function automatic logic span_fits(input logic [31:0] a, input logic [31:0] len,
                                     input logic [31:0] base, input logic [31:0] size);
    span_fits = (a >= base) && (({1'b0, a} + {1'b0, len}) <= ({1'b0, base} + {1'b0, size}));
  endfunction

  // point a inside [base, base+size], end inclusive
  function automatic logic point_fits(input logic [31:0] a,
                                      input logic [31:0] base, input logic [31:0] size);
    point_fits = (a >= base) && ({1'b0, a} <= ({1'b0, base} + {1'b0, size}));
  endfunction

endpackage

// File: rtl/fdf_chan_regs.sv
module fdf_chan_regs
  import fdf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_ptr,
  input  logic        wr_branch,
  input  logic [31:0] wdata,
  input  logic        clr_src,
  input  logic        load,
  input  logic [31:0] ld_next,
  input  logic [31:0] ld_src,
  input  logic [31:0] ld_id,
  input  logic [31:0] ld_cmd,
  input  logic        take_branch,
  output logic [31:0] ptr_q,
  output logic [31:0] src_q,
  output logic [31:0] id_q,
  output logic [31:0] cmd_q,
  output logic [31:0] branch_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      src_q    <= '0;
      id_q     <= '0;
      cmd_q    <= '0;
      branch_q <= '0;
    end else begin
      if (clr_src) src_q <= '0;
      if (load) begin
        ptr_q <= ld_next;
        src_q <= ld_src;
        id_q  <= ld_id;
        cmd_q <= ld_cmd;
      end else if (wr_ptr) begin
        ptr_q <= wdata & PTR_MASK;
      end
      if (wr_branch)        branch_q    <= wdata & BRANCH_MASK;
      else if (take_branch) branch_q[0] <= 1'b0;
    end
  end

  // R6: a consumed redirect request is gone the next cycle unless software rewrote it
  assert_branch_oneshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_branch && !wr_branch |=> !branch_q[0]);

  // R4: a load never coincides with the frame-start clear
  assert_clear_not_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_src |-> !load);

endmodule

// File: rtl/fdf_seq.sv
module fdf_seq
  import fdf_pkg::*;
#(
  parameter int          NCH     = 7,
  parameter int          CW      = 3,
  parameter logic [31:0] W0_BASE = 32'h0000_1000,
  parameter logic [31:0] W0_SIZE = 32'h0000_1000,
  parameter logic [31:0] W1_BASE = 32'h0004_0000,
  parameter logic [31:0] W1_SIZE = 32'h0000_0100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_start,
  input  logic [NCH-1:0]        chan_en,
  input  logic [NCH-1:0][31:0]  ptr_vec,
  input  logic [NCH-1:0]        br_req,
  input  logic [NCH-1:0]        br_int,
  input  logic [NCH-1:0][27:0]  br_addr,
  output logic                  clr_src,
  output logic [NCH-1:0]        load_vec,
  output logic [NCH-1:0]        take_vec,
  output logic [31:0]           ld_next,
  output logic [31:0]           ld_src,
  output logic [31:0]           ld_id,
  output logic [31:0]           ld_cmd,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic [31:0]           mem_req_addr,
  input  logic                  mem_rsp_valid,
  output logic                  mem_rsp_ready,
  input  logic [31:0]           mem_rsp_data,
  output logic                  busy,
  output logic [NCH-1:0]        bs_event,
  output logic                  ber_event,
  output logic [CW-1:0]         ber_chan
);

  localparam logic [CW-1:0] LAST_CH = CW'(NCH - 1);

  seq_state_t        state_q;
  logic [CW-1:0]     ch_q;
  logic [1:0]        widx_q;
  logic [31:0]       base_q;
  logic [2:0][31:0]  buf_q;

  logic [31:0] pick_ptr;
  logic        pick_ok;
  logic        src_ok;

  assign pick_ptr = br_req[ch_q] ? {br_addr[ch_q], 4'b0000} : ptr_vec[ch_q];
  assign pick_ok  = span_fits(pick_ptr, DESC_BYTES, W0_BASE, W0_SIZE) ||
                    span_fits(pick_ptr, DESC_BYTES, W1_BASE, W1_SIZE);
  assign src_ok   = (buf_q[1] != 32'd0) &&
                    (point_fits(buf_q[1], W0_BASE, W0_SIZE) ||
                     point_fits(buf_q[1], W1_BASE, W1_SIZE));

  always_comb begin
    take_vec = '0;
    load_vec = '0;
    if (state_q == S_PICK && chan_en[ch_q] && br_req[ch_q]) take_vec[ch_q] = 1'b1;
    if (state_q == S_RSP && mem_rsp_valid && widx_q == 2'd3) load_vec[ch_q] = 1'b1;
  end

  assign bs_event      = take_vec & br_int;
  assign clr_src       = (state_q == S_IDLE) && frame_start;
  assign mem_req_valid = (state_q == S_REQ);
  assign mem_req_addr  = base_q + {28'd0, widx_q, 2'b00};
  assign mem_rsp_ready = (state_q == S_RSP);
  assign ld_next       = buf_q[0];
  assign ld_src        = buf_q[1];
  assign ld_id         = buf_q[2];
  assign ld_cmd        = mem_rsp_data;
  assign ber_event     = (state_q == S_CHECK) && !src_ok;
  assign ber_chan      = ch_q;
  assign busy          = (state_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ch_q    <= '0;
      widx_q  <= '0;
      base_q  <= '0;
      buf_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (frame_start) begin
          ch_q    <= '0;
          state_q <= S_PICK;
        end
        S_PICK: begin
          buf_q  <= '0;
          widx_q <= '0;
          base_q <= pick_ptr;
          if (!chan_en[ch_q]) state_q <= S_NEXT;
          else if (pick_ok)   state_q <= S_REQ;
          else                state_q <= S_CHECK;
        end
        S_REQ: if (mem_req_ready) state_q <= S_RSP;
        S_RSP: if (mem_rsp_valid) begin
          case (widx_q)
            2'd0:    buf_q[0] <= mem_rsp_data;
            2'd1:    buf_q[1] <= mem_rsp_data;
            2'd2:    buf_q[2] <= mem_rsp_data;
            default: ;
          endcase
          if (widx_q == 2'd3) begin
            state_q <= S_CHECK;
          end else begin
            widx_q  <= widx_q + 2'd1;
            state_q <= S_REQ;
          end
        end
        S_CHECK: state_q <= S_NEXT;
        S_NEXT: begin
          if (ch_q == LAST_CH) begin
            state_q <= S_IDLE;
          end else begin
            ch_q    <= ch_q + 1'b1;
            state_q <= S_PICK;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R10: a stalled request keeps its address
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R10: never request and wait for a response in the same cycle
  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready));

  // R7: every word requested lies inside a window
  assert_req_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (span_fits(mem_req_addr, 32'd4, W0_BASE, W0_SIZE) ||
                       span_fits(mem_req_addr, 32'd4, W1_BASE, W1_SIZE)));

  // R9: an accepted frame start makes the block busy
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !busy |=> busy);

  // R9: no memory traffic while idle
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !mem_rsp_ready);

  // R6: at most one branch event at a time
  assert_bs_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bs_event));

  // R8: bus errors never overlap a memory transfer
  assert_ber_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ber_event |-> !mem_req_valid && !mem_rsp_ready);

endmodule

// File: rtl/frame_desc_fetcher.sv
module frame_desc_fetcher
  import fdf_pkg::*;
#(
  parameter int          NCH     = 7,
  parameter int          REG_AW  = 12,
  parameter logic [31:0] W0_BASE = 32'h0000_1000,
  parameter logic [31:0] W0_SIZE = 32'h0000_1000,
  parameter logic [31:0] W1_BASE = 32'h0004_0000,
  parameter logic [31:0] W1_SIZE = 32'h0000_0100,
  localparam int         CW      = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [NCH-1:0]    chan_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [31:0]       mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [31:0]       mem_rsp_data,
  output logic              busy,
  output logic [NCH-1:0]    bs_event,
  output logic              ber_event,
  output logic [CW-1:0]     ber_chan
);

  localparam int CH_BASE = 'h200;
  localparam int CH_STEP = 16;
  localparam int BR_BASE = 'h100;
  localparam int BR_STEP = 4;

  logic [NCH-1:0][31:0] ptr_vec, src_vec, id_vec, cmd_vec, branch_vec;
  logic [NCH-1:0][27:0] br_addr;
  logic [NCH-1:0]       br_req, br_int, wr_ptr, wr_branch, load_vec, take_vec;
  logic                 clr_src;
  logic [31:0]          ld_next, ld_src, ld_id, ld_cmd;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign wr_ptr[k]    = reg_wr && (reg_addr == REG_AW'(CH_BASE + CH_STEP * k));
    assign wr_branch[k] = reg_wr && (reg_addr == REG_AW'(BR_BASE + BR_STEP * k));
    assign br_req[k]    = branch_vec[k][0];
    assign br_int[k]    = branch_vec[k][1];
    assign br_addr[k]   = branch_vec[k][31:4];

    fdf_chan_regs u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_ptr      (wr_ptr[k]),
      .wr_branch   (wr_branch[k]),
      .wdata       (reg_wdata),
      .clr_src     (clr_src),
      .load        (load_vec[k]),
      .ld_next     (ld_next),
      .ld_src      (ld_src),
      .ld_id       (ld_id),
      .ld_cmd      (ld_cmd),
      .take_branch (take_vec[k]),
      .ptr_q       (ptr_vec[k]),
      .src_q       (src_vec[k]),
      .id_q        (id_vec[k]),
      .cmd_q       (cmd_vec[k]),
      .branch_q    (branch_vec[k])
    );
  end

  fdf_seq #(
    .NCH(NCH), .CW(CW),
    .W0_BASE(W0_BASE), .W0_SIZE(W0_SIZE), .W1_BASE(W1_BASE), .W1_SIZE(W1_SIZE)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .chan_en       (chan_en),
    .ptr_vec       (ptr_vec),
    .br_req        (br_req),
    .br_int        (br_int),
    .br_addr       (br_addr),
    .clr_src       (clr_src),
    .load_vec      (load_vec),
    .take_vec      (take_vec),
    .ld_next       (ld_next),
    .ld_src        (ld_src),
    .ld_id         (ld_id),
    .ld_cmd        (ld_cmd),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_data  (mem_rsp_data),
    .busy          (busy),
    .bs_event      (bs_event),
    .ber_event     (ber_event),
    .ber_chan      (ber_chan)
  );

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NCH; k++) begin
      if (reg_addr == REG_AW'(BR_BASE + BR_STEP * k))       reg_rdata = branch_vec[k];
      if (reg_addr == REG_AW'(CH_BASE + CH_STEP * k))       reg_rdata = ptr_vec[k];
      if (reg_addr == REG_AW'(CH_BASE + CH_STEP * k + 4))   reg_rdata = src_vec[k];
      if (reg_addr == REG_AW'(CH_BASE + CH_STEP * k + 8))   reg_rdata = id_vec[k];
      if (reg_addr == REG_AW'(CH_BASE + CH_STEP * k + 12))  reg_rdata = cmd_vec[k];
    end
  end

  // R4: every source register is zero right after an accepted frame start
  assert_src_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && !busy |=> src_vec == '0);

  // R6: a branch event needs both the request and the event flag in that channel
  assert_bs_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bs_event & ~(br_req & br_int)) == '0);

  // R8: the reported channel always exists
  assert_ber_chan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ber_event |-> int'(ber_chan) < NCH);

  // R2: a pointer written by software is 16-byte aligned
  assert_ptr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr[0] && !load_vec[0] |=> ptr_vec[0][3:0] == 4'd0);

endmodule

// File: tb/test_frame_desc_fetcher.sv
module test_frame_desc_fetcher;

  localparam int NCH = 7;
  localparam int CW  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frame_start = 1'b0;
  logic [NCH-1:0]    chan_en = '0;
  logic [11:0]       reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic [31:0]       mem_req_addr;
  logic              mem_rsp_valid = 1'b0;
  logic              mem_rsp_ready;
  logic [31:0]       mem_rsp_data = '0;
  logic              busy;
  logic [NCH-1:0]    bs_event;
  logic              ber_event;
  logic [CW-1:0]     ber_chan;

  always #5 clk = ~clk;

  frame_desc_fetcher i_frame_desc_fetcher (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .chan_en(chan_en),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .busy(busy), .bs_event(bs_event), .ber_event(ber_event), .ber_chan(ber_chan)
  );

  int n_chk = 0;
  int n_bad = 0;

  // behavioural memory: window0 0x1000..0x1FFF, window1 0x40000..0x400FF
  logic [31:0] memw [0:1087];
  logic [31:0] log_addr [0:255];
  int          n_log = 0;
  int          n_oob = 0;
  int          bs_cnt [NCH];
  int          ber_cnt = 0;
  int          ber_last = 0;
  logic        stall = 1'b0;
  logic [7:0]  cyc = '0;
  logic        pend = 1'b0;
  int          dly = 0;
  logic [31:0] pdata = '0;

  function automatic int widx(input logic [31:0] a);
    if (a >= 32'h1000 && a < 32'h2000)   return int'((a - 32'h1000) >> 2);
    if (a >= 32'h40000 && a < 32'h40100) return 1024 + int'((a - 32'h40000) >> 2);
    return -1;
  endfunction

  initial begin
    for (int i = 0; i < 1088; i++) memw[i] = '0;
    for (int i = 0; i < NCH; i++) bs_cnt[i] = 0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    mem_req_ready <= !stall || cyc[1];
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        log_addr[n_log[7:0]] <= mem_req_addr;
        n_log <= n_log + 1;
        pend <= 1'b1;
        dly <= stall ? 2 : 0;
        if (widx(mem_req_addr) < 0) begin
          n_oob <= n_oob + 1;
          pdata <= 32'hDEAD_BEEF;
        end else begin
          pdata <= memw[widx(mem_req_addr)];
        end
      end else if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data <= pdata;
          pend <= 1'b0;
        end else begin
          dly <= dly - 1;
        end
      end
      for (int k = 0; k < NCH; k++) if (bs_event[k]) bs_cnt[k] <= bs_cnt[k] + 1;
      if (ber_event) begin
        ber_cnt <= ber_cnt + 1;
        ber_last <= int'(ber_chan);
      end
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = 12'(a);
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 12'(a);
    #1 d = reg_rdata;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] s,
                          input logic [31:0] id, input logic [31:0] cmd);
    memw[widx(a)]     = nx;
    memw[widx(a + 4)] = s;
    memw[widx(a + 8)] = id;
    memw[widx(a + 12)] = cmd;
  endtask

  task automatic pulse();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic run_frame();
    int n;
    pulse();
    check("R9 busy after frame start", {31'd0, busy}, 32'd1);
    n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check("R9 pass completes", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 busy low", {31'd0, busy}, 32'd0);
    check("R1 no request", {31'd0, mem_req_valid}, 32'd0);
    check("R1 no events", {24'd0, bs_event, ber_event}, 32'd0);
    for (int k = 0; k < NCH; k++) begin
      rd('h200 + 16 * k, d); check("R1 pointer zero", d, 0);
      rd('h204 + 16 * k, d); check("R1 source zero", d, 0);
      rd('h100 + 4 * k, d);  check("R1 branch zero", d, 0);
    end
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr('h220, 32'h1234_567F); rd('h220, d); check("R2 pointer mask", d, 32'h1234_5670);
    wr('h224, 32'hFFFF_FFFF); rd('h224, d); check("R2 source read-only", d, 0);
    wr('h228, 32'hFFFF_FFFF); rd('h228, d); check("R2 id read-only", d, 0);
    wr('h22C, 32'hFFFF_FFFF); rd('h22C, d); check("R2 command read-only", d, 0);
    wr('h10C, 32'hFFFF_FFFF); rd('h10C, d); check("R3 branch mask", d, 32'hFFFF_FFF3);
    wr('h10C, 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] d;
    int s;
    put_desc(32'h1000, 32'h1010, 32'h1800, 32'hAB, 32'h0460_0040);
    wr('h200, 32'h1000);
    chan_en = 7'b0000001;
    s = n_log;
    run_frame();
    check("R5 word count", 32'(n_log - s), 4);
    for (int i = 0; i < 4; i++) check("R10 word address order", log_addr[s + i], 32'h1000 + 32'(4 * i));
    rd('h200, d); check("R5 next pointer loaded", d, 32'h1010);
    rd('h204, d); check("R5 source loaded", d, 32'h1800);
    rd('h208, d); check("R5 id loaded", d, 32'hAB);
    rd('h20C, d); check("R5 command loaded", d, 32'h0460_0040);
    check("R8 no error on good source", 32'(ber_cnt), 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    int s;
    chan_en = '0;
    s = n_log;
    run_frame();
    check("R4 disabled makes no request", 32'(n_log - s), 0);
    rd('h204, d); check("R4 source cleared", d, 0);
    rd('h200, d); check("R4 pointer kept", d, 32'h1010);
    rd('h208, d); check("R4 id kept", d, 32'hAB);
    check("R8 no error for disabled", 32'(ber_cnt), 0);
  endtask

  task automatic t_branch();
    logic [31:0] d;
    int s, b;
    put_desc(32'h1020, 32'h1020, 32'h1900, 32'h11, 32'h0);
    put_desc(32'h1040, 32'h1020, 32'h1A00, 32'h77, 32'h0);
    wr('h210, 32'h1020);
    wr('h104, 32'h1043);
    chan_en = 7'b0000010;
    b = bs_cnt[1];
    s = n_log;
    run_frame();
    check("R6 branch address used", log_addr[s], 32'h1040);
    rd('h214, d); check("R6 source from branch target", d, 32'h1A00);
    rd('h104, d); check("R6 request bit cleared", d, 32'h1042);
    check("R6 branch event raised", 32'(bs_cnt[1] - b), 1);
    s = n_log;
    run_frame();
    check("R6 chain resumes", log_addr[s], 32'h1020);
    rd('h214, d); check("R6 source from chain", d, 32'h1900);
    check("R6 one-shot event", 32'(bs_cnt[1] - b), 1);
    wr('h104, 32'h1041);
    s = n_log;
    run_frame();
    check("R6 quiet branch address used", log_addr[s], 32'h1040);
    check("R6 no event without flag", 32'(bs_cnt[1] - b), 1);
    rd('h104, d); check("R6 quiet request cleared", d, 32'h1040);
  endtask

  task automatic t_range();
    logic [31:0] d;
    int s, e;
    chan_en = 7'b0000100;
    wr('h220, 32'h2000);
    e = ber_cnt;
    s = n_log;
    run_frame();
    check("R7 outside descriptor not read", 32'(n_log - s), 0);
    rd('h224, d); check("R7 source stays zero", d, 0);
    check("R8 error on skipped descriptor", 32'(ber_cnt - e), 1);
    check("R8 error channel", 32'(ber_last), 2);
    put_desc(32'h1FF0, 32'h1FF0, 32'h2000, 32'h5, 32'h0);
    wr('h220, 32'h1FF0);
    e = ber_cnt;
    s = n_log;
    run_frame();
    check("R7 descriptor at window end fetched", 32'(n_log - s), 4);
    rd('h224, d); check("R8 source at window end kept", d, 32'h2000);
    check("R8 no error at inclusive end", 32'(ber_cnt - e), 0);
    put_desc(32'h400F0, 32'h400F0, 32'h0, 32'h6, 32'h0);
    wr('h220, 32'h400F0);
    e = ber_cnt;
    s = n_log;
    run_frame();
    check("R7 second window end fetched", 32'(n_log - s), 4);
    check("R8 error on zero source", 32'(ber_cnt - e), 1);
    put_desc(32'h400F0, 32'h400F0, 32'h3000, 32'h6, 32'h0);
    e = ber_cnt;
    run_frame();
    check("R8 error on outside source", 32'(ber_cnt - e), 1);
    check("R8 error channel again", 32'(ber_last), 2);
  endtask

  task automatic t_order();
    logic [31:0] d;
    int s;
    stall = 1'b1;
    put_desc(32'h1100, 32'h1100, 32'h1A00, 32'h1, 32'h0);
    put_desc(32'h1200, 32'h1200, 32'h1B00, 32'h3, 32'h0);
    put_desc(32'h40000, 32'h40000, 32'h40080, 32'h6, 32'h0);
    wr('h200, 32'h1100);
    wr('h230, 32'h1200);
    wr('h260, 32'h40000);
    chan_en = 7'b1001001;
    s = n_log;
    pulse();
    repeat (3) @(negedge clk);
    pulse();
    while (busy) @(negedge clk);
    check("R10 stalled word count", 32'(n_log - s), 12);
    for (int i = 0; i < 4; i++) begin
      check("R9 channel 0 first", log_addr[s + i], 32'h1100 + 32'(4 * i));
      check("R9 channel 3 second", log_addr[s + 4 + i], 32'h1200 + 32'(4 * i));
      check("R9 channel 6 last", log_addr[s + 8 + i], 32'h40000 + 32'(4 * i));
    end
    repeat (10) @(negedge clk);
    check("R9 frame start while busy ignored", {31'd0, busy}, 0);
    check("R9 no extra words", 32'(n_log - s), 12);
    rd('h264, d); check("R5 channel 6 source", d, 32'h40080);
    rd('h238, d); check("R5 channel 3 id", d, 32'h3);
    stall = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_basic();
    t_disabled();
    t_branch();
    t_range();
    t_order();
    check("R7 no access outside windows", 32'(n_oob), 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule